// File: doc/BRIEF.md
# SDRAM Presence-Detect Image Generator

This block builds the 256-byte presence-detect image that describes one SDRAM module. A host gives it a memory family (SDR, DDR or DDR2) and the total module size, written as log2 of the size in megabytes, and pulses `start`. The block first splits the size into a bank count and a per-bank size, using limits that depend on the family. From the per-bank size it derives the density byte, folded in a way that depends on the family. It then emits the image one byte per clock as index/data pairs. While it does so it keeps a running sum of the leading bytes, which it places in the checksum slot, and it signals the end of the image with a single-cycle `done` pulse.

If the request is invalid, the block emits no bytes at all and raises a one-cycle `error` pulse instead. A request is invalid when the family code is unknown or when the size is below the smallest per-bank size for that family. A `start` that arrives while an image is being streamed is ignored. The byte stream can be written directly into a serial EEPROM model, with the index used as the write address.

Top module: `spd_image_gen`

## Requirements
- R1: After reset, `byte_valid`, `done` and `error` are all 0 until a request is accepted.
- R2: An accepted request produces exactly 256 consecutive cycles with `byte_valid`=1, and `byte_index` runs from 0 to 255. Index 0 appears in the second cycle after the clock edge that sampled `start`.
- R3: The bank count starts at 1. While the size log2 is above the family maximum (SDR 9, DDR 12, DDR2 14) and there are fewer than 8 banks, the size log2 is reduced by one and the bank count is doubled.
- R4: If the result is still one bank and the per-bank size log2 is above the family minimum (SDR 2, DDR 5, DDR2 7), the module is reported as 2 banks of half the size.
- R5: The density is raw = 1 << (bank size log2 − 2), and byte 31 carries it folded per family. SDR uses raw[7:0]. DDR uses {raw[7:3], raw[10:8]}. DDR2 uses {raw[7:5], raw[12:8]}.
- R6: The fixed bytes take these values, and every byte not named in R6 to R8 is 0:
  - byte 2 is the family code: 4 for SDR (type input 0), 7 for DDR (type input 1), 8 for DDR2 (type input 2);
  - bytes 0 and 1 are 128 and 8;
  - bytes 3 and 4 are 13 and 10;
  - byte 6 is 64, byte 8 is 4, byte 9 is 0x25;
  - byte 12 is 0x82 and byte 13 is 8;
  - bytes 16, 17, 18 and 20 are 12, 4, 12 and 2;
  - byte 23 is 0x12;
  - bytes 27 to 30 are 20, 15, 20, 45;
  - bytes 32 to 35 are 20, 8, 20, 8.
- R7: Byte 5 is the bank count minus 1 for DDR2 and the bank count for the other families. Bytes 15 and 19 are 0 for DDR2 and 1 otherwise. Byte 21 is 0x20 for SDR and DDR and 0 for DDR2.
- R8: Byte 63 equals the sum of bytes 0 to 62, modulo 256.
- R9: `done` is 1 for exactly the one cycle that follows the cycle carrying index 255.
- R10: A type input of 3, or a size below the family minimum, raises `error` for one cycle, in the cycle after the edge that sampled `start`. No byte and no `done` follow.
- R11: A `start` pulse while bytes are being streamed is ignored. The stream continues unchanged, and neither `error` nor a second stream follows from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse; sampled only when idle |
| mem_type | input | 2 | Family: 0 SDR, 1 DDR, 2 DDR2, 3 invalid |
| size_log2 | input | 5 | Total module size as log2 of megabytes |
| byte_valid | output | 1 | Current index/data pair is valid |
| byte_index | output | 8 | Image byte index |
| byte_data | output | 8 | Image byte value |
| done | output | 1 | One-cycle end-of-image pulse |
| error | output | 1 | One-cycle rejected-request pulse |

## Verification
The bench drives `start` on a falling edge and samples every output on later falling edges. Counting from the rising edge that takes `start`, `error` is due one cycle later and byte 0 two cycles later. Byte k is due k+2 cycles later, and `done` is due 258 cycles later. The bench steps through exactly those falling edges one at a time and compares each index/data pair with an image it builds itself from the family and size. It also checks that the error path stays silent in the cycles that follow the pulse, and that a `start` injected in the middle of a stream leaves the stream's indices and data untouched.

// File: rtl/spd_pkg.sv
package spd_pkg;
  typedef enum logic [1:0] {MT_SDR = 2'd0, MT_DDR = 2'd1, MT_DDR2 = 2'd2, MT_BAD = 2'd3} mem_kind_t;

  localparam int IMG_BYTES  = 256;
  localparam int IDX_W      = $clog2(IMG_BYTES);
  localparam int CSUM_SLOT  = 63;
  localparam int BANK_STEPS = 3;           // up to 2**3 = 8 banks
  localparam int BANK_W     = BANK_STEPS + 1;

  function automatic logic [4:0] kind_min(input mem_kind_t k);
    case (k)
      MT_SDR:  return 5'd2;
      MT_DDR:  return 5'd5;
      default: return 5'd7;
    endcase
  endfunction

  function automatic logic [4:0] kind_max(input mem_kind_t k);
    case (k)
      MT_SDR:  return 5'd9;
      MT_DDR:  return 5'd12;
      default: return 5'd14;
    endcase
  endfunction

  function automatic logic [7:0] kind_code(input mem_kind_t k);
    case (k)
      MT_SDR:  return 8'd4;
      MT_DDR:  return 8'd7;
      default: return 8'd8;
    endcase
  endfunction

  // Fold a raw density word into one byte, family dependent.
  function automatic logic [7:0] fold_density(input mem_kind_t k, input logic [31:0] raw);
    case (k)
      MT_DDR2: return (raw[7:0] & 8'hE0) | (raw[15:8] & 8'h1F);
      MT_DDR:  return (raw[7:0] & 8'hF8) | (raw[15:8] & 8'h07);
      default: return raw[7:0];
    endcase
  endfunction
endpackage

// File: rtl/spd_geom.sv
module spd_geom
  import spd_pkg::*;
#(
  parameter int SIZE_W = 5
) (
  input  mem_kind_t               kind,
  input  logic [SIZE_W-1:0]       size_log2,
  output logic [BANK_W-1:0]       banks,
  output logic [7:0]              density
);
  logic [SIZE_W-1:0] bank_l2;
  logic [1:0]        steps;
  logic              split_hit;
  logic [31:0]       raw;

  always_comb begin
    bank_l2 = size_log2;
    steps   = 2'd0;
    for (int k = 0; k < BANK_STEPS; k++) begin
      if (bank_l2 > SIZE_W'(kind_max(kind))) begin
        bank_l2 = bank_l2 - 1'b1;
        steps   = steps + 2'd1;
      end
    end
    split_hit = (steps == 2'd0) && (bank_l2 > SIZE_W'(kind_min(kind)));
    if (split_hit) begin
      bank_l2 = bank_l2 - 1'b1;
      steps   = 2'd1;
    end
    banks   = BANK_W'(1) << steps;
    raw     = 32'd1 << (bank_l2 - SIZE_W'(2));
    density = fold_density(kind, raw);
  end

  // R3: bank count is a power of two no larger than 8
  always_comb begin
    a_r3_banks_pow2: assert ($countones(banks) == 1);
  end
endmodule

// File: rtl/spd_rom.sv
module spd_rom
  import spd_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  mem_kind_t         kind,
  input  logic [BANK_W-1:0] banks,
  input  logic [7:0]        density,
  output logic [7:0]        value
);
  logic is_ddr2;
  assign is_ddr2 = (kind == MT_DDR2);

  always_comb begin
    case (idx)
      8'd0:  value = 8'd128;
      8'd1:  value = 8'd8;
      8'd2:  value = kind_code(kind);
      8'd3:  value = 8'd13;
      8'd4:  value = 8'd10;
      8'd5:  value = is_ddr2 ? 8'(banks - 1'b1) : 8'(banks);
      8'd6:  value = 8'd64;
      8'd8:  value = 8'd4;
      8'd9:  value = 8'h25;
      8'd12: value = 8'h82;
      8'd13: value = 8'd8;
      8'd15: value = is_ddr2 ? 8'd0 : 8'd1;
      8'd16: value = 8'd12;
      8'd17: value = 8'd4;
      8'd18: value = 8'd12;
      8'd19: value = is_ddr2 ? 8'd0 : 8'd1;
      8'd20: value = 8'd2;
      8'd21: value = is_ddr2 ? 8'd0 : 8'h20;
      8'd23: value = 8'h12;
      8'd27: value = 8'd20;
      8'd28: value = 8'd15;
      8'd29: value = 8'd20;
      8'd30: value = 8'd45;
      8'd31: value = density;
      8'd32: value = 8'd20;
      8'd33: value = 8'd8;
      8'd34: value = 8'd20;
      8'd35: value = 8'd8;
      default: value = 8'd0;
    endcase
  end
endmodule

// File: rtl/spd_seq.sv
module spd_seq
  import spd_pkg::*;
#(
  parameter int SIZE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mem_type,
  input  logic [SIZE_W-1:0] size_log2,
  input  logic [7:0]        rom_value,
  output mem_kind_t         kind_q,
  output logic [SIZE_W-1:0] size_q,
  output logic [IDX_W-1:0]  cnt_q,
  output logic              byte_valid,
  output logic [IDX_W-1:0]  byte_index,
  output logic [7:0]        byte_data,
  output logic              done,
  output logic              error
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(IMG_BYTES - 1);
  localparam logic [IDX_W-1:0] CSUM_IDX = IDX_W'(CSUM_SLOT);

  logic      streaming;
  logic [7:0] csum_q;
  mem_kind_t req_kind;
  logic      req_bad;
  logic      accept;
  logic      last_step;

  assign req_kind  = mem_kind_t'(mem_type);
  assign req_bad   = (req_kind == MT_BAD) || (size_log2 < SIZE_W'(kind_min(req_kind)));
  assign accept    = start && !streaming;
  assign last_step = streaming && (cnt_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      streaming  <= 1'b0;
      kind_q     <= MT_SDR;
      size_q     <= '0;
      cnt_q      <= '0;
      csum_q     <= '0;
      byte_valid <= 1'b0;
      byte_index <= '0;
      byte_data  <= '0;
      done       <= 1'b0;
      error      <= 1'b0;
    end else begin
      error <= accept && req_bad;
      done  <= byte_valid && (byte_index == LAST_IDX);
      if (accept && !req_bad) begin
        streaming <= 1'b1;
        kind_q    <= req_kind;
        size_q    <= size_log2;
        cnt_q     <= '0;
        csum_q    <= '0;
      end
      byte_valid <= streaming;
      if (streaming) begin
        byte_index <= cnt_q;
        byte_data  <= (cnt_q == CSUM_IDX) ? csum_q : rom_value;
        if (cnt_q < CSUM_IDX) csum_q <= csum_q + rom_value;
        cnt_q <= cnt_q + 1'b1;
        if (last_step) streaming <= 1'b0;
      end
    end
  end

  // R10: a rejected request never coincides with streamed data
  a_r10_no_bytes_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !byte_valid);
  // R9: done only right after the final index
  a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(byte_valid && byte_index == LAST_IDX));
  // R2: indices advance by one without gaps
  a_r2_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && byte_index != LAST_IDX) |=> (byte_valid && byte_index == $past(byte_index) + 1'b1));
  // R2: a stream begins at index 0
  a_r2_first_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_valid) |-> (byte_index == '0));
  // R11: an active stream is not cut short or restarted
  a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (streaming && cnt_q != LAST_IDX) |=> (streaming && cnt_q == $past(cnt_q) + 1'b1));
  // R8: checksum frozen once its slot has been emitted
  a_r8_sum_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (streaming && cnt_q > CSUM_IDX) |=> $stable(csum_q));
endmodule

// File: rtl/spd_image_gen.sv
module spd_image_gen
  import spd_pkg::*;
#(
  parameter int SIZE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mem_type,
  input  logic [SIZE_W-1:0] size_log2,
  output logic              byte_valid,
  output logic [7:0]        byte_index,
  output logic [7:0]        byte_data,
  output logic              done,
  output logic              error
);
  mem_kind_t         kind_q;
  logic [SIZE_W-1:0] size_q;
  logic [IDX_W-1:0]  cnt_q;
  logic [BANK_W-1:0] banks;
  logic [7:0]        density;
  logic [7:0]        rom_value;

  spd_seq #(.SIZE_W(SIZE_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mem_type   (mem_type),
    .size_log2  (size_log2),
    .rom_value  (rom_value),
    .kind_q     (kind_q),
    .size_q     (size_q),
    .cnt_q      (cnt_q),
    .byte_valid (byte_valid),
    .byte_index (byte_index),
    .byte_data  (byte_data),
    .done       (done),
    .error      (error)
  );

  spd_geom #(.SIZE_W(SIZE_W)) u_geom (
    .kind      (kind_q),
    .size_log2 (size_q),
    .banks     (banks),
    .density   (density)
  );

  spd_rom u_rom (
    .idx     (cnt_q),
    .kind    (kind_q),
    .banks   (banks),
    .density (density),
    .value   (rom_value)
  );

  // R1: the two pulse outputs never overlap
  a_r1_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
endmodule

// File: tb/spd_image_gen_bench.sv
module spd_image_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] mem_type = 2'd0;
  logic [4:0] size_log2 = 5'd0;
  logic       byte_valid, done, error;
  logic [7:0] byte_index, byte_data;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [7:0] want [0:255];

  always #2 clk = ~clk;   // 250 MHz

  spd_image_gen u_spd_image_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_type(mem_type),
    .size_log2(size_log2), .byte_valid(byte_valid), .byte_index(byte_index),
    .byte_data(byte_data), .done(done), .error(error)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic bit is_bad(input int t, input int s);
    int lo;
    if (t == 3) return 1;
    lo = (t == 0) ? 2 : (t == 1) ? 5 : 7;
    return s < lo;
  endfunction

  // Expected image built from R3..R8
  task automatic build(input int t, input int s);
    int lo, hi, ex, nb, sl, sum;
    logic [63:0] raw;
    logic [7:0] dens;
    lo = (t == 0) ? 2 : (t == 1) ? 5 : 7;
    hi = (t == 0) ? 9 : (t == 1) ? 12 : 14;
    ex = s - hi;
    if (ex < 0) ex = 0;
    if (ex > 3) ex = 3;
    nb = 1 << ex;
    sl = s - ex;
    if (nb == 1 && sl > lo) begin nb = 2; sl = sl - 1; end
    raw = 64'd1 << (sl - 2);
    if (t == 2)      dens = {raw[7:5], raw[12:8]};
    else if (t == 1) dens = {raw[7:3], raw[10:8]};
    else             dens = raw[7:0];
    for (int i = 0; i < 256; i++) want[i] = 8'd0;
    want[0] = 128; want[1] = 8; want[2] = (t == 0) ? 4 : (t == 1) ? 7 : 8;
    want[3] = 13; want[4] = 10; want[5] = 8'((t == 2) ? nb - 1 : nb);
    want[6] = 64; want[8] = 4; want[9] = 8'h25; want[12] = 8'h82; want[13] = 8;
    want[15] = (t == 2) ? 0 : 1; want[19] = want[15];
    want[16] = 12; want[17] = 4; want[18] = 12; want[20] = 2;
    want[21] = (t == 2) ? 8'h00 : 8'h20; want[23] = 8'h12;
    want[27] = 20; want[28] = 15; want[29] = 20; want[30] = 45; want[31] = dens;
    want[32] = 20; want[33] = 8; want[34] = 20; want[35] = 8;
    sum = 0;
    for (int i = 0; i < 63; i++) sum += want[i];
    want[63] = 8'(sum);
  endtask

  task automatic run(input int t, input int s, input bit poke);
    @(negedge clk);
    mem_type = 2'(t); size_log2 = 5'(s); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (is_bad(t, s)) begin
      chk("R10 error pulse", error, 1);
      chk("R10 no byte", byte_valid, 0);
      @(negedge clk);
      chk("R10 error one cycle", error, 0);
      chk("R10 still silent", byte_valid, 0);
      @(negedge clk);
      chk("R10 no done", done, 0);
      chk("R10 no late byte", byte_valid, 0);
      return;
    end
    build(t, s);
    chk("R1 no error on good request", error, 0);
    chk("R2 nothing before start latency", byte_valid, 0);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      chk("R2 valid", byte_valid, 1);
      chk("R2 index", byte_index, 32'(i));
      if (i == 63) chk("R8 checksum", byte_data, want[i]);
      else if (i == 31) chk("R5 density", byte_data, want[i]);
      else if (i == 5 || i == 15 || i == 19 || i == 21) chk("R7 family byte", byte_data, want[i]);
      else chk("R6 image byte", byte_data, want[i]);
      if (i != 255) chk("R9 no early done", done, 0);
      chk("R11 no error mid stream", error, 0);
      if (poke && i == 10) begin mem_type = 2'd3; start = 1'b1; end
      else if (poke && i == 11) begin start = 1'b0; mem_type = 2'(t); end
    end
    @(negedge clk);
    chk("R9 done", done, 1);
    chk("R9 stream ended", byte_valid, 0);
    @(negedge clk);
    chk("R9 done one cycle", done, 0);
    chk("R11 no second stream", byte_valid, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset valid", byte_valid, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset error", error, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", byte_valid | done | error, 0);
    run(0, 2, 0);    // SDR at minimum, single bank R4 boundary
    run(0, 3, 1);    // SDR split to two banks, mid-stream start R11
    run(1, 13, 0);   // DDR one step above max R3
    run(2, 20, 0);   // DDR2 far above max, capped at 8 banks
    run(2, 7, 0);    // DDR2 at minimum
    run(2, 6, 0);    // below minimum R10
    run(3, 10, 0);   // invalid family R10
    run(1, 17, 0);   // DDR capped at 8 banks with leftover
    for (int n = 0; n < 20; n++) run(int'($urandom % 4), int'($urandom % 22), n == 5);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule